// File: doc/BRIEF.md
# SPI Host Interrupt, Error and Event Controller

This block sits beside the data path of a serial-peripheral host and turns its error and event conditions into two interrupt lines. Error conditions arrive as single-cycle pulses or are found by checking a command as it is issued. They are recorded in sticky error-status bits that software clears by writing 1. Status conditions arrive as levels from the FIFOs and the core: flags plus word counts. Some of them raise an event on a rising or falling edge. The two watermark conditions are levels and raise the event on every cycle they hold.

The block also screens each command. A command goes to the core (`cmd_accept_o`) only when the core is ready, the command fields are legal, the chip-select index is in range and no error-status bit is pending. A small register port, with a write strobe, a 3-bit word address, write data and combinational read data, gives access to the enables, the watermarks, the interrupt state and test bits, and a one-cycle alert-test pulse.

Register word addresses: 0 watermarks (RX level in bits 7:0, TX level in bits 15:8); 1 interrupt state; 2 interrupt enable; 3 interrupt test; 4 error enable; 5 error status; 6 event enable; 7 alert test. The interrupt test and alert test registers read as 0. Interrupt bits: bit 0 is the error interrupt and bit 1 is the event interrupt.

Top module: `spi_irq_ctrl`

## Requirements
- R1: After reset the watermark register reads 0x007F (RX level 0x7F, TX level 0), error enable reads 0x1F, event enable, interrupt state, interrupt enable and error status read 0, and both interrupt pins are low.
- R2: `irq_err_o` is interrupt state bit 0 AND enable bit 0, and `irq_evt_o` is state bit 1 AND enable bit 1. Writing 1 to a state bit at address 1 clears it. A set in the same cycle wins over the clear.
- R3: Writing 1 to bit 0 or bit 1 at address 3 sets the matching interrupt state bit on the next clock edge.
- R4: Error-status bits (address 5) are sticky and are cleared by writing 1. Bit 0 is a command while the core is not ready, bit 1 is a TX overflow, bit 2 is an RX underflow, bit 3 is an invalid command, bit 4 is a chip-select index out of range, and bit 5 is a TX write with no byte enables. A new error in the same cycle wins over the clear.
- R5: A new error of class 0 to 4 sets interrupt state bit 0 only when its error-enable bit is 1, and the status bit is recorded either way. Class 5 always sets interrupt state bit 0.
- R6: A command is invalid when its speed is 3, or when its direction is 3 and its speed is not 0. Its chip-select index is out of range when it is at or above NUM_CS. A command issued with `core_ready_i` low records error bit 0.
- R7: `cmd_accept_o` is high only for a command issued with `core_ready_i` high, legal fields, a chip-select index in range and all error-status bits clear.
- R8: Event enable bits are: 0 RX full, 1 TX empty, 2 RX watermark, 3 TX watermark, 4 ready, 5 idle. RX full, TX empty and ready fire when their flag rises. Idle fires when `active_i` falls. Each edge is found against the flag value of the previous cycle. Any enabled event sets interrupt state bit 1.
- R9: The TX watermark event holds while the TX word count is below the TX level. It sets the state again on every cycle, so a clear does not stick while the condition holds.
- R10: The RX watermark event holds while the RX word count is at or above the RX level.
- R11: Writing 1 to bit 0 at address 7 makes `alert_o` high for exactly the one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 2*DEPTH_W | Write data |
| reg_rdata_o | output | 2*DEPTH_W | Read data for reg_addr_i (combinational) |
| cmd_valid_i | input | 1 | Command issued this cycle |
| cmd_speed_i | input | 2 | Command speed: 0 single, 1 dual, 2 quad, 3 illegal |
| cmd_dir_i | input | 2 | Command direction: 3 is bidirectional |
| cmd_csid_i | input | CSID_W | Chip-select index of the command |
| cmd_accept_o | output | 1 | Command passed to the core |
| core_ready_i | input | 1 | Core ready for a command |
| active_i | input | 1 | Core busy with a command |
| tx_ovf_i | input | 1 | TX FIFO overflow pulse |
| rx_udf_i | input | 1 | RX read-while-empty pulse |
| tx_nobe_i | input | 1 | TX write with no byte enables pulse |
| rx_full_i | input | 1 | RX FIFO full flag |
| tx_empty_i | input | 1 | TX FIFO empty flag |
| tx_depth_i | input | DEPTH_W | TX FIFO word count |
| rx_depth_i | input | DEPTH_W | RX FIFO word count |
| irq_err_o | output | 1 | Error interrupt |
| irq_evt_o | output | 1 | Event interrupt |
| alert_o | output | 1 | Alert-test pulse |

## Verification
The assertions assume that each error input is a pulse lasting one cycle per event, and that the status flags and counts change only at clock edges. The stimulus drives every input on the falling clock edge and holds each error pulse for exactly one cycle. It changes a flag only while no register write is pending, so that each edge event and each clear can be told apart. Command fields are only considered while `cmd_valid_i` is high, and the bench returns `cmd_valid_i` to 0 after one cycle.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    typedef enum logic [2:0] {
        A_WMARK    = 3'd0,
        A_IRQ_STAT = 3'd1,
        A_IRQ_EN   = 3'd2,
        A_IRQ_TEST = 3'd3,
        A_ERR_EN   = 3'd4,
        A_ERR_STAT = 3'd5,
        A_EVT_EN   = 3'd6,
        A_ALERT    = 3'd7
    } reg_addr_e;

    localparam int ERR_N       = 6;
    localparam int ERR_MASKED  = 5;
    localparam int EVT_N       = 6;
    localparam int IRQ_N       = 2;

    localparam int E_BUSY  = 0;
    localparam int E_OVF   = 1;
    localparam int E_UDF   = 2;
    localparam int E_INVAL = 3;
    localparam int E_CSID  = 4;
    localparam int E_NOBE  = 5;

    localparam int V_RXFULL  = 0;
    localparam int V_TXEMPTY = 1;
    localparam int V_RXWM    = 2;
    localparam int V_TXWM    = 3;
    localparam int V_READY   = 4;
    localparam int V_IDLE    = 5;

    localparam logic [1:0] SPEED_BAD = 2'd3;
    localparam logic [1:0] DIR_BIDIR = 2'd3;

endpackage

// File: rtl/spi_err_unit.sv
module spi_err_unit
    import spi_irq_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int CSID_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cmd_valid_i,
    input  logic [1:0]        cmd_speed_i,
    input  logic [1:0]        cmd_dir_i,
    input  logic [CSID_W-1:0] cmd_csid_i,
    input  logic              core_ready_i,
    input  logic              tx_ovf_i,
    input  logic              rx_udf_i,
    input  logic              tx_nobe_i,
    input  logic [ERR_N-1:0]  clr_i,
    output logic [ERR_N-1:0]  hit_o,
    output logic [ERR_N-1:0]  status_o,
    output logic              accept_o
);
    localparam logic [CSID_W-1:0] CS_LIMIT = CSID_W'(NUM_CS);

    logic              fields_bad;
    logic              csid_bad;
    logic [ERR_N-1:0]  status_q;

    always_comb begin
        fields_bad = (cmd_speed_i == SPEED_BAD) ||
                     ((cmd_dir_i == DIR_BIDIR) && (cmd_speed_i != 2'd0));
        csid_bad   = (cmd_csid_i >= CS_LIMIT);
        hit_o          = '0;
        hit_o[E_BUSY]  = cmd_valid_i && !core_ready_i;
        hit_o[E_OVF]   = tx_ovf_i;
        hit_o[E_UDF]   = rx_udf_i;
        hit_o[E_INVAL] = cmd_valid_i && fields_bad;
        hit_o[E_CSID]  = cmd_valid_i && csid_bad;
        hit_o[E_NOBE]  = tx_nobe_i;
        accept_o = cmd_valid_i && core_ready_i && !fields_bad &&
                   !csid_bad && (status_q == '0);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) status_q <= '0;
        else         status_q <= (status_q & ~clr_i) | hit_o;
    end

    assign status_o = status_q;
endmodule

// File: rtl/spi_evt_unit.sv
module spi_evt_unit
    import spi_irq_pkg::*;
#(
    parameter int DEPTH_W = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               rx_full_i,
    input  logic               tx_empty_i,
    input  logic               ready_i,
    input  logic               active_i,
    input  logic [DEPTH_W-1:0] tx_depth_i,
    input  logic [DEPTH_W-1:0] rx_depth_i,
    input  logic [DEPTH_W-1:0] tx_level_i,
    input  logic [DEPTH_W-1:0] rx_level_i,
    output logic [EVT_N-1:0]   hit_o
);
    logic rx_full_q, tx_empty_q, ready_q, active_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rx_full_q  <= 1'b0;
            tx_empty_q <= 1'b0;
            ready_q    <= 1'b0;
            active_q   <= 1'b0;
        end else begin
            rx_full_q  <= rx_full_i;
            tx_empty_q <= tx_empty_i;
            ready_q    <= ready_i;
            active_q   <= active_i;
        end
    end

    always_comb begin
        hit_o            = '0;
        hit_o[V_RXFULL]  = rx_full_i && !rx_full_q;
        hit_o[V_TXEMPTY] = tx_empty_i && !tx_empty_q;
        hit_o[V_RXWM]    = (rx_depth_i >= rx_level_i);
        hit_o[V_TXWM]    = (tx_depth_i < tx_level_i);
        hit_o[V_READY]   = ready_i && !ready_q;
        hit_o[V_IDLE]    = !active_i && active_q;
    end
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
    import spi_irq_pkg::*;
#(
    parameter int NUM_CS  = 4,
    parameter int CSID_W  = 32,
    parameter int DEPTH_W = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 reg_we_i,
    input  logic [2:0]           reg_addr_i,
    input  logic [2*DEPTH_W-1:0] reg_wdata_i,
    output logic [2*DEPTH_W-1:0] reg_rdata_o,
    input  logic                 cmd_valid_i,
    input  logic [1:0]           cmd_speed_i,
    input  logic [1:0]           cmd_dir_i,
    input  logic [CSID_W-1:0]    cmd_csid_i,
    output logic                 cmd_accept_o,
    input  logic                 core_ready_i,
    input  logic                 active_i,
    input  logic                 tx_ovf_i,
    input  logic                 rx_udf_i,
    input  logic                 tx_nobe_i,
    input  logic                 rx_full_i,
    input  logic                 tx_empty_i,
    input  logic [DEPTH_W-1:0]   tx_depth_i,
    input  logic [DEPTH_W-1:0]   rx_depth_i,
    output logic                 irq_err_o,
    output logic                 irq_evt_o,
    output logic                 alert_o
);
    localparam int REG_W = 2 * DEPTH_W;
    localparam logic [DEPTH_W-1:0] RX_LEVEL_RST = DEPTH_W'(8'h7F);

    reg_addr_e             addr;
    logic                  wr_wmark, wr_istat, wr_ien, wr_itest;
    logic                  wr_een, wr_estat, wr_ven, wr_alert;

    logic [DEPTH_W-1:0]    rx_level_q, tx_level_q;
    logic [IRQ_N-1:0]      irq_q, irq_en_q, irq_set, irq_clr, irq_tst;
    logic [ERR_MASKED-1:0] err_en_q;
    logic [EVT_N-1:0]      evt_en_q, evt_hit;
    logic [ERR_N-1:0]      err_hit, err_status, err_clr;
    logic                  alert_q;

    always_comb begin
        addr     = reg_addr_e'(reg_addr_i);
        wr_wmark = reg_we_i && (addr == A_WMARK);
        wr_istat = reg_we_i && (addr == A_IRQ_STAT);
        wr_ien   = reg_we_i && (addr == A_IRQ_EN);
        wr_itest = reg_we_i && (addr == A_IRQ_TEST);
        wr_een   = reg_we_i && (addr == A_ERR_EN);
        wr_estat = reg_we_i && (addr == A_ERR_STAT);
        wr_ven   = reg_we_i && (addr == A_EVT_EN);
        wr_alert = reg_we_i && (addr == A_ALERT);
    end

    assign err_clr = wr_estat ? reg_wdata_i[ERR_N-1:0] : '0;

    spi_err_unit #(.NUM_CS(NUM_CS), .CSID_W(CSID_W)) u_err (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cmd_valid_i (cmd_valid_i),
        .cmd_speed_i (cmd_speed_i),
        .cmd_dir_i   (cmd_dir_i),
        .cmd_csid_i  (cmd_csid_i),
        .core_ready_i(core_ready_i),
        .tx_ovf_i    (tx_ovf_i),
        .rx_udf_i    (rx_udf_i),
        .tx_nobe_i   (tx_nobe_i),
        .clr_i       (err_clr),
        .hit_o       (err_hit),
        .status_o    (err_status),
        .accept_o    (cmd_accept_o)
    );

    spi_evt_unit #(.DEPTH_W(DEPTH_W)) u_evt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rx_full_i  (rx_full_i),
        .tx_empty_i (tx_empty_i),
        .ready_i    (core_ready_i),
        .active_i   (active_i),
        .tx_depth_i (tx_depth_i),
        .rx_depth_i (rx_depth_i),
        .tx_level_i (tx_level_q),
        .rx_level_i (rx_level_q),
        .hit_o      (evt_hit)
    );

    always_comb begin
        irq_set    = '0;
        irq_set[0] = (|(err_hit[ERR_MASKED-1:0] & err_en_q)) | err_hit[E_NOBE];
        irq_set[1] = |(evt_hit & evt_en_q);
        irq_clr    = wr_istat ? reg_wdata_i[IRQ_N-1:0] : '0;
        irq_tst    = wr_itest ? reg_wdata_i[IRQ_N-1:0] : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rx_level_q <= RX_LEVEL_RST;
            tx_level_q <= '0;
            irq_en_q   <= '0;
            err_en_q   <= '1;
            evt_en_q   <= '0;
            irq_q      <= '0;
            alert_q    <= 1'b0;
        end else begin
            if (wr_wmark) begin
                rx_level_q <= reg_wdata_i[DEPTH_W-1:0];
                tx_level_q <= reg_wdata_i[REG_W-1:DEPTH_W];
            end
            if (wr_ien) irq_en_q <= reg_wdata_i[IRQ_N-1:0];
            if (wr_een) err_en_q <= reg_wdata_i[ERR_MASKED-1:0];
            if (wr_ven) evt_en_q <= reg_wdata_i[EVT_N-1:0];
            irq_q   <= (irq_q & ~irq_clr) | irq_set | irq_tst;
            alert_q <= wr_alert && reg_wdata_i[0];
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        unique case (addr)
            A_WMARK:    reg_rdata_o = {tx_level_q, rx_level_q};
            A_IRQ_STAT: reg_rdata_o[IRQ_N-1:0] = irq_q;
            A_IRQ_EN:   reg_rdata_o[IRQ_N-1:0] = irq_en_q;
            A_ERR_EN:   reg_rdata_o[ERR_MASKED-1:0] = err_en_q;
            A_ERR_STAT: reg_rdata_o[ERR_N-1:0] = err_status;
            A_EVT_EN:   reg_rdata_o[EVT_N-1:0] = evt_en_q;
            A_IRQ_TEST, A_ALERT: reg_rdata_o = '0;
        endcase
    end

    assign irq_err_o = irq_q[0] & irq_en_q[0];
    assign irq_evt_o = irq_q[1] & irq_en_q[1];
    assign alert_o   = alert_q;
endmodule

// File: rtl/spi_irq_ctrl_chk.sv
module spi_irq_ctrl_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       reg_we_i,
    input logic [2:0] reg_addr_i,
    input logic [1:0] reg_wdata_lo,
    input logic       cmd_accept_o,
    input logic       core_ready_i,
    input logic       tx_ovf_i,
    input logic       active_i,
    input logic       alert_o,
    input logic [5:0] err_status,
    input logic [4:0] err_en_q,
    input logic [5:0] evt_en_q,
    input logic [1:0] irq_q
);
    // R4
    err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(reg_we_i && reg_addr_i == 3'd5) |=> (($past(err_status) & ~err_status) == 6'd0));

    // R7
    cmd_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_accept_o |-> (core_ready_i && err_status == 6'd0));

    // R5
    ovf_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_ovf_i && err_en_q[1]) |=> irq_q[0]);

    // R3
    irq_test_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_we_i && reg_addr_i == 3'd3 && reg_wdata_lo[1]) |=> irq_q[1]);

    // R8
    idle_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_en_q[5] && $fell(active_i)) |=> irq_q[1]);

    // R11
    alert_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        alert_o |=> !alert_o);
endmodule

bind spi_irq_ctrl spi_irq_ctrl_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .reg_we_i     (reg_we_i),
    .reg_addr_i   (reg_addr_i),
    .reg_wdata_lo (reg_wdata_i[1:0]),
    .cmd_accept_o (cmd_accept_o),
    .core_ready_i (core_ready_i),
    .tx_ovf_i     (tx_ovf_i),
    .active_i     (active_i),
    .alert_o      (alert_o),
    .err_status   (err_status),
    .err_en_q     (err_en_q),
    .evt_en_q     (evt_en_q),
    .irq_q        (irq_q)
);

// File: tb/spi_irq_ctrl_tb.sv
module spi_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_speed = 2'd0, cmd_dir = 2'd0;
    logic [31:0] cmd_csid = '0;
    logic        cmd_accept;
    logic        core_ready = 1'b1, active = 1'b0;
    logic        tx_ovf = 1'b0, rx_udf = 1'b0, tx_nobe = 1'b0;
    logic        rx_full = 1'b0, tx_empty = 1'b0;
    logic [7:0]  tx_depth = '0, rx_depth = '0;
    logic        irq_err, irq_evt, alert;
    int          checks = 0, errors = 0;

    always #10 clk = ~clk;

    spi_irq_ctrl u_dut (
        .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .cmd_valid_i(cmd_valid),
        .cmd_speed_i(cmd_speed), .cmd_dir_i(cmd_dir), .cmd_csid_i(cmd_csid),
        .cmd_accept_o(cmd_accept), .core_ready_i(core_ready), .active_i(active),
        .tx_ovf_i(tx_ovf), .rx_udf_i(rx_udf), .tx_nobe_i(tx_nobe),
        .rx_full_i(rx_full), .tx_empty_i(tx_empty), .tx_depth_i(tx_depth),
        .rx_depth_i(rx_depth), .irq_err_o(irq_err), .irq_evt_o(irq_evt),
        .alert_o(alert)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input string tag, input logic [15:0] exp);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic issue(input logic [1:0] sp, input logic [1:0] dr, input logic [31:0] cs,
                         input logic exp_acc, input string tag);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_speed = sp; cmd_dir = dr; cmd_csid = cs;
        #1;
        chk(tag, cmd_accept, exp_acc);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic t_reset;
        rd(3'd0, "R1 wmark", 16'h007F);
        rd(3'd4, "R1 err_en", 16'h001F);
        rd(3'd6, "R1 evt_en", 16'h0000);
        rd(3'd1, "R1 irq_state", 16'h0000);
        rd(3'd2, "R1 irq_en", 16'h0000);
        rd(3'd5, "R1 err_status", 16'h0000);
        chk("R1 pins", {irq_err, irq_evt}, 0);
    endtask

    task automatic t_error_path;
        wr(3'd2, 16'h0001);
        @(negedge clk); tx_ovf = 1'b1;
        @(negedge clk); tx_ovf = 1'b0;
        rd(3'd5, "R4 ovf status", 16'h0002);
        rd(3'd1, "R5 ovf irq", 16'h0001);
        chk("R2 irq_err pin", irq_err, 1);
        wr(3'd5, 16'h0002);
        rd(3'd5, "R4 w1c", 16'h0000);
        rd(3'd1, "R2 state held", 16'h0001);
        wr(3'd1, 16'h0001);
        rd(3'd1, "R2 w1c", 16'h0000);
        chk("R2 pin low", irq_err, 0);
    endtask

    task automatic t_mask;
        wr(3'd4, 16'h001D);
        @(negedge clk); tx_ovf = 1'b1;
        @(negedge clk); tx_ovf = 1'b0;
        rd(3'd5, "R5 masked status", 16'h0002);
        rd(3'd1, "R5 masked no irq", 16'h0000);
        wr(3'd5, 16'h003F);
        wr(3'd4, 16'h0000);
        @(negedge clk); tx_nobe = 1'b1;
        @(negedge clk); tx_nobe = 1'b0;
        rd(3'd5, "R4 nobe bit5", 16'h0020);
        rd(3'd1, "R5 nobe unmasked", 16'h0001);
        @(negedge clk); rx_udf = 1'b1;
        @(negedge clk); rx_udf = 1'b0;
        rd(3'd5, "R4 udf bit2", 16'h0024);
        wr(3'd5, 16'h003F);
        wr(3'd1, 16'h0003);
        wr(3'd4, 16'h001F);
    endtask

    task automatic t_command;
        issue(2'd0, 2'd3, 32'd1, 1'b1, "R7 legal accept");
        rd(3'd5, "R6 legal no err", 16'h0000);
        issue(2'd1, 2'd3, 32'd1, 1'b0, "R6 dual bidir refuse");
        rd(3'd5, "R6 dual bidir", 16'h0008);
        issue(2'd0, 2'd1, 32'd0, 1'b0, "R7 pending error refuse");
        wr(3'd5, 16'h0008);
        issue(2'd3, 2'd1, 32'd0, 1'b0, "R6 speed3 refuse");
        rd(3'd5, "R6 speed3", 16'h0008);
        wr(3'd5, 16'h0008);
        issue(2'd2, 2'd2, 32'd4, 1'b0, "R6 csid refuse");
        rd(3'd5, "R6 csid range", 16'h0010);
        wr(3'd5, 16'h0010);
        issue(2'd2, 2'd2, 32'd3, 1'b1, "R6 csid top ok");
        core_ready = 1'b0;
        issue(2'd0, 2'd0, 32'd0, 1'b0, "R7 not ready refuse");
        rd(3'd5, "R6 busy", 16'h0001);
        core_ready = 1'b1;
        wr(3'd5, 16'h003F);
        wr(3'd1, 16'h0003);
    endtask

    task automatic t_test;
        wr(3'd2, 16'h0000);
        wr(3'd3, 16'h0002);
        rd(3'd1, "R3 test sets", 16'h0002);
        chk("R2 masked pin", irq_evt, 0);
        wr(3'd2, 16'h0003);
        chk("R2 evt pin", irq_evt, 1);
        rd(3'd3, "R3 test reads 0", 16'h0000);
        wr(3'd1, 16'h0003);
    endtask

    task automatic t_edges;
        wr(3'd6, 16'h0002);
        tx_empty = 1'b1;
        tick;
        rd(3'd1, "R8 txempty rise", 16'h0002);
        wr(3'd1, 16'h0002);
        tick;
        rd(3'd1, "R8 txempty level no refire", 16'h0000);
        wr(3'd6, 16'h0020);
        active = 1'b1;
        tick; tick;
        rd(3'd1, "R8 active rise silent", 16'h0000);
        active = 1'b0;
        tick;
        rd(3'd1, "R8 idle fall", 16'h0002);
        wr(3'd1, 16'h0002);
        wr(3'd6, 16'h0001);
        rx_full = 1'b1;
        tick;
        rd(3'd1, "R8 rxfull rise", 16'h0002);
        rx_full = 1'b0;
        wr(3'd1, 16'h0002);
    endtask

    task automatic t_watermarks;
        tx_depth = 8'd4;
        wr(3'd0, 16'h047F);
        wr(3'd6, 16'h0008);
        wr(3'd1, 16'h0003);
        rd(3'd1, "R9 at level quiet", 16'h0000);
        tx_depth = 8'd2;
        tick;
        rd(3'd1, "R9 below level", 16'h0002);
        wr(3'd1, 16'h0002);
        rd(3'd1, "R9 refire after clear", 16'h0002);
        tx_depth = 8'd4;
        wr(3'd1, 16'h0002);
        rd(3'd1, "R9 cleared", 16'h0000);
        wr(3'd6, 16'h0004);
        wr(3'd0, 16'h0403);
        rx_depth = 8'd2;
        tick;
        rd(3'd1, "R10 below quiet", 16'h0000);
        rx_depth = 8'd3;
        tick;
        rd(3'd1, "R10 at level", 16'h0002);
        rx_depth = 8'd0;
        wr(3'd1, 16'h0002);
    endtask

    task automatic t_alert;
        chk("R11 idle low", alert, 0);
        wr(3'd7, 16'h0001);
        chk("R11 pulse", alert, 1);
        tick;
        chk("R11 one cycle", alert, 0);
        rd(3'd7, "R11 reads 0", 16'h0000);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick;
        t_reset;
        t_error_path;
        t_mask;
        t_command;
        t_test;
        t_edges;
        t_watermarks;
        t_alert;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule